// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block registers a 14-bit command/address word on every rising clock edge and drives it onto two identical output copies, so one input line can feed twice the load. The controller also sends a parity bit some cycles after each word. The block merges that bit with the XOR of the word and reports the result on a partial-parity output and an active-low error flag.

A static mode input sets the role of the device. In standalone mode (or as the front device of a pair), the parity bit follows its word by one edge. In back mode, the parity input is wired straight to the front device's partial-parity output, and the result comes out one cycle later than in standalone mode. When both chip-select inputs are high, the outputs freeze. A synchronous active-high reset clears every register and takes priority over the freeze.

Top module: `cmd_reg_buf`

## Requirements
- R1: The 14-bit `d` is captured on each rising edge of `clk`, and after that edge both `q_a` and `q_b` carry the captured word.
- R2: At every rising edge with `rst` high, all registers clear: `q_a`, `q_b` and `ppo` become 0 and `err_n` becomes 1. This holds even when both selects are high.
- R3: At an edge where `sel_a` and `sel_b` are both high, `q_a`, `q_b`, `ppo` and `err_n` keep their values. If either select is low, the outputs update normally.
- R4: With `mode_back` = 0, `par_in` is sampled on the first edge after the word's capture edge, and `ppo`/`err_n` for that word update on the second edge after it.
- R5: With `mode_back` = 1, `par_in` is sampled on the third edge after the word's capture edge, and `ppo`/`err_n` update on that same edge. A front device's `ppo` can therefore drive `par_in` directly.
- R6: `ppo` is the XOR of all 14 bits of the word and its matching `par_in`, so even parity is expected. `err_n` goes low when that value is 1. The selects take no part in the computation.
- R7: After an error, `err_n` stays low for two cycles (parameter `ERR_HOLD`). A new error restarts the hold, and reset ends it at once.
- R8: After reset is released, `ppo` and `err_n` report nothing (0 and 1) for parity samples that belong to words from before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_back | input | 1 | 0: standalone/front, 1: back device of a pair |
| sel_a | input | 1 | Chip select A; with sel_b high, freezes the outputs |
| sel_b | input | 1 | Chip select B |
| d | input | 14 | Command/address word |
| par_in | input | 1 | Parity bit from the controller or the front device |
| q_a | output | 14 | Registered word, copy A |
| q_b | output | 14 | Registered word, copy B |
| ppo | output | 1 | Partial parity out (word XOR parity bit) |
| err_n | output | 1 | Parity error flag, active low |

## Verification
A word driven before edge e is due on `q_a`/`q_b` right after edge e. Its standalone parity result is due after edge e+2, and the back device's result after edge e+3. The driver stamps each expected item with that due edge and sends traffic on every cycle, so a result is due at each cycle. The monitor compares only at the falling edge that follows the due edge, and it works out the two-cycle error hold from the sequence of expected results. Freeze, reset inside an error pulse and the empty pipeline after reset are checked directly at the falling edge after the edge concerned.

// File: rtl/cmd_reg_buf_pkg.sv
package cmd_reg_buf_pkg;
  // Edge count from capture to result in back mode; also the data-parity delay line depth.
  localparam int BACK_LAT = 3;

  typedef enum logic {
    MODE_SOLO = 1'b0,
    MODE_BACK = 1'b1
  } mode_e;
endpackage

// File: rtl/rcb_data_reg.sv
module rcb_data_reg #(
  parameter int DW     = 14,
  parameter int COPIES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       freeze,
  input  logic [DW-1:0]              d,
  output logic [COPIES-1:0][DW-1:0]  q
);
  // One register bank per output copy so each copy can sit near its load.
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= '0;
      else if (!freeze)
        q[i] <= d;
    end
  end
endmodule

// File: rtl/rcb_parity_pipe.sv
module rcb_parity_pipe
  import cmd_reg_buf_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_back,
  input  logic [DW-1:0] d,
  input  logic          par_in,
  output logic          res_ppo
);
  // Word parity and a valid bit, delayed once per edge after capture.
  logic [BACK_LAT-1:0] dpar_sr;
  logic [BACK_LAT-1:0] vld_sr;
  // Standalone stage: word parity merged with the parity bit one edge later.
  logic                sum_q;
  logic                sum_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      dpar_sr <= '0;
      vld_sr  <= '0;
      sum_q   <= 1'b0;
      sum_vld <= 1'b0;
    end else begin
      dpar_sr <= {dpar_sr[BACK_LAT-2:0], ^d};
      vld_sr  <= {vld_sr[BACK_LAT-2:0], 1'b1};
      sum_q   <= dpar_sr[0] ^ par_in;
      sum_vld <= vld_sr[0];
    end
  end

  // Back mode merges the late parity bit on the output edge itself.
  always_comb begin
    if (mode_back == MODE_BACK)
      res_ppo = (dpar_sr[BACK_LAT-1] ^ par_in) & vld_sr[BACK_LAT-1];
    else
      res_ppo = sum_q & sum_vld;
  end
endmodule

// File: rtl/rcb_err_out.sv
module rcb_err_out #(
  parameter int ERR_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic res_ppo,
  output logic ppo,
  output logic err_n
);
  localparam int CW = $clog2(ERR_HOLD + 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ppo      <= 1'b0;
      err_n    <= 1'b1;
      hold_cnt <= '0;
    end else if (!freeze) begin
      ppo <= res_ppo;
      if (res_ppo) begin
        err_n    <= 1'b0;
        hold_cnt <= CW'(ERR_HOLD - 1);
      end else if (hold_cnt != '0) begin
        err_n    <= 1'b0;
        hold_cnt <= hold_cnt - 1'b1;
      end else begin
        err_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf #(
  parameter int DATA_W   = 14,
  parameter int ERR_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_back,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic [DATA_W-1:0] d,
  input  logic              par_in,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b,
  output logic              ppo,
  output logic              err_n
);
  localparam int COPIES = 2;

  logic                          freeze;
  logic                          res_ppo;
  logic [COPIES-1:0][DATA_W-1:0] q_copies;

  assign freeze = sel_a & sel_b;

  rcb_data_reg #(.DW(DATA_W), .COPIES(COPIES)) u_data (
    .clk    (clk),
    .rst    (rst),
    .freeze (freeze),
    .d      (d),
    .q      (q_copies)
  );

  rcb_parity_pipe #(.DW(DATA_W)) u_par (
    .clk       (clk),
    .rst       (rst),
    .mode_back (mode_back),
    .d         (d),
    .par_in    (par_in),
    .res_ppo   (res_ppo)
  );

  rcb_err_out #(.ERR_HOLD(ERR_HOLD)) u_err (
    .clk     (clk),
    .rst     (rst),
    .freeze  (freeze),
    .res_ppo (res_ppo),
    .ppo     (ppo),
    .err_n   (err_n)
  );

  assign q_a = q_copies[0];
  assign q_b = q_copies[1];
endmodule

// File: rtl/cmd_reg_buf_chk.sv
module cmd_reg_buf_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_a,
  input logic          sel_b,
  input logic [DW-1:0] q_a,
  input logic [DW-1:0] q_b,
  input logic          ppo,
  input logic          err_n
);
  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (rst)
    q_a == q_b); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q_a == '0 && q_b == '0 && !ppo && err_n)); // R2

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sel_a && sel_b) |=> ($stable(q_a) && $stable(ppo) && $stable(err_n))); // R3

  AST_PPO_FLAGS_ERR: assert property (@(posedge clk) disable iff (rst)
    !(sel_a && sel_b) |=> (!ppo || !err_n)); // R6

  AST_ERR_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!err_n && $past(err_n) && !(sel_a && sel_b)) |=> !err_n); // R7
endmodule

bind cmd_reg_buf cmd_reg_buf_chk #(.DW(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sel_a (sel_a),
  .sel_b (sel_b),
  .q_a   (q_a),
  .q_b   (q_b),
  .ppo   (ppo),
  .err_n (err_n)
);

// File: tb/cmd_reg_buf_tb.sv
module cmd_reg_buf_tb;
  typedef struct packed {
    int          due;
    logic [13:0] val;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_a = 1'b0, sel_b = 1'b0;
  logic [13:0] d_f = '0, d_b = '0;
  logic        par_in_f = 1'b0;
  logic [13:0] q_a, q_b, qb_a, qb_b;
  logic        ppo_f, err_f, ppo_bk, err_bk;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  logic pend_f = 1'b0;
  int hold_f = 0, hold_b = 0;
  item_t qd[$], qf[$], qb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_reg_buf u_dut (
    .clk(clk), .rst(rst), .mode_back(1'b0), .sel_a(sel_a), .sel_b(sel_b),
    .d(d_f), .par_in(par_in_f), .q_a(q_a), .q_b(q_b), .ppo(ppo_f), .err_n(err_f)
  );

  cmd_reg_buf u_back (
    .clk(clk), .rst(rst), .mode_back(1'b1), .sel_a(1'b0), .sel_b(1'b0),
    .d(d_b), .par_in(ppo_f), .q_a(qb_a), .q_b(qb_b), .ppo(ppo_bk), .err_n(err_bk)
  );

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp_v);
    end
  endtask

  // Driver: one word per cycle; parity bit of the previous word goes out alongside it.
  task automatic step(input logic [13:0] w, input logic [13:0] w2, input logic bad);
    int e;
    @(negedge clk);
    e = cyc + 1;
    d_f      = w;
    d_b      = w2;
    par_in_f = pend_f;
    pend_f   = (^w) ^ bad;
    if (!rst && sb_on) begin
      qd.push_back('{due: e,     val: w});
      qf.push_back('{due: e + 2, val: {13'd0, bad}});
      qb.push_back('{due: e + 3, val: {13'd0, (^w2) ^ bad}});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst   = 1'b1;
    sb_on = 1'b0;
    repeat (2) @(negedge clk);
    qd.delete(); qf.delete(); qb.delete();
    hold_f = 0; hold_b = 0;
    d_f = '0; d_b = '0;
    par_in_f = 1'b1;   // stale parity sample that must be ignored (R8)
    pend_f   = 1'b0;
    rst   = 1'b0;
    sb_on = 1'b1;
  endtask

  // Monitor: compare each expected item at the falling edge after its due edge.
  always @(negedge clk) begin
    item_t it;
    logic  exp_e;
    if (sb_on) begin
      if (qd.size() > 0 && qd[0].due == cyc) begin
        it = qd.pop_front();
        chk("R1 q_a", q_a, it.val);
        chk("R1 q_b", q_b, it.val);
      end
      if (qf.size() > 0 && qf[0].due == cyc) begin
        it = qf.pop_front();
        exp_e = !(it.val[0] || hold_f > 0);
        chk("R4/R6 front ppo", {13'd0, ppo_f}, it.val);
        chk("R7 front err_n", {13'd0, err_f}, {13'd0, exp_e});
        if (it.val[0]) hold_f = 1; else if (hold_f > 0) hold_f--;
      end
      if (qb.size() > 0 && qb[0].due == cyc) begin
        it = qb.pop_front();
        exp_e = !(it.val[0] || hold_b > 0);
        chk("R5/R6 back ppo", {13'd0, ppo_bk}, it.val);
        chk("R5/R7 back err_n", {13'd0, err_bk}, {13'd0, exp_e});
        if (it.val[0]) hold_b = 1; else if (hold_b > 0) hold_b--;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] w2, fq;
    logic fp, fe;
    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 reset q_a", q_a, '0);
    chk("R2 reset ppo", {13'd0, ppo_f}, '0);
    chk("R2 reset err_n", {13'd0, err_f}, 14'd1);

    // R8: stale parity after release must not flag
    do_reset();
    @(negedge clk);
    chk("R8 front ppo after release", {13'd0, ppo_f}, '0);
    chk("R8 front err_n after release", {13'd0, err_f}, 14'd1);
    par_in_f = 1'b0;
    @(negedge clk);
    chk("R8 front err_n second cycle", {13'd0, err_f}, 14'd1);
    chk("R8 back err_n", {13'd0, err_bk}, 14'd1);

    // Scoreboard traffic: standalone front with looped back device (R1 R3 R4 R5 R6 R7)
    for (int i = 0; i < 40; i++) begin
      w2 = 14'(i * 91 + 3);
      if (^w2) w2 = w2 ^ 14'd1;
      if (i == 28) w2 = 14'h0001;          // back-only parity error
      sel_a = (i >= 15 && i <= 25);        // one select high: no freeze (R3)
      step(14'(i * 37 + 5), w2, (i == 5 || i == 12 || i == 13 || i == 20));
    end
    sel_a = 1'b0;
    repeat (4) step(14'h0f0f, 14'h0000, 1'b0);

    // R7: reset cuts an error pulse short
    sb_on = 1'b0;
    step(14'h1234, 14'h0000, 1'b1);
    step(14'h0003, 14'h0000, 1'b0);
    step(14'h0005, 14'h0000, 1'b0);
    @(negedge clk);
    chk("R7 err_n low before reset", {13'd0, err_f}, '0);
    rst = 1'b1;
    @(negedge clk);
    chk("R7/R2 err_n released by reset", {13'd0, err_f}, 14'd1);
    chk("R2 q_a cleared by reset", q_a, '0);
    chk("R2 ppo cleared by reset", {13'd0, ppo_f}, '0);
    do_reset();

    // R3: freeze with both selects high
    sb_on = 1'b0;
    step(14'h0aaa, 14'h0000, 1'b1);
    step(14'h0111, 14'h0000, 1'b0);
    step(14'h0222, 14'h0000, 1'b0);
    @(negedge clk);
    sel_a = 1'b1; sel_b = 1'b1;
    fq = q_a; fp = ppo_f; fe = err_f;
    for (int k = 0; k < 5; k++) begin
      step(14'(k * 777 + 1), 14'h0000, (k == 1));
      chk("R3 frozen q_a", q_a, fq);
      chk("R3 frozen ppo", {13'd0, ppo_f}, {13'd0, fp});
      chk("R3 frozen err_n", {13'd0, err_f}, {13'd0, fe});
    end
    // R2: reset overrides freeze
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R2 reset beats freeze q_a", q_a, '0);
    chk("R2 reset beats freeze err_n", {13'd0, err_f}, 14'd1);
    sel_a = 1'b0; sel_b = 1'b0;
    do_reset();
    repeat (4) step(14'h0000, 14'h0000, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule